// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block checks one 256-byte data chunk against a 3-byte single-error-correcting Hamming code. On a start pulse it takes two 24-bit codes: the code computed over the data as it streamed in, and the code that was kept beside the data in the spare area. It XORs them into a syndrome and sorts the result into one of four outcomes: clean, a single flipped data bit, a damaged stored code, or an uncorrectable pattern.

For a single data-bit error it reports the byte address and the bit to invert. It can also perform the repair itself, by a read-modify-write on the chunk buffer it holds. A host fills and drains that buffer through a simple write port and a registered read port. For a damaged stored code it raises a one-cycle request, together with the computed code that should replace the stored one. A compatibility input selects a variant in which the computed code is inverted bitwise, and then has bits 17:16 forced high, before it is compared.

Top module: `hecc_corrector`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_valid`, `busy` and `code_wr` are 0 and `res_status`, `res_byte`, `res_bit`, `code_new` are all zero.
- R2: A `start` accepted while `busy` is low raises `res_valid` for exactly one cycle, in the cycle after the start. The result outputs then hold until the next accepted start. An all-zero syndrome gives `res_status` 2'b00.
- R3: Let d1 = syndrome[7:0], d2 = syndrome[15:8] and d3 = syndrome[23:16]. Bits 7/6, 5/4, 3/2 and 1/0 of d1 must differ, and so must those of d2; bits 7/6, 5/4 and 3/2 of d3 must differ. When all of this holds, `res_status` is 2'b01 and `res_byte` is {d1[7],d1[5],d1[3],d1[1],d2[7],d2[5],d2[3],d2[1]}.
- R4: For status 2'b01, `res_bit` is {d3[7],d3[5],d3[3]}. For any other status, `res_byte` and `res_bit` are 0.
- R5: For status 2'b01 with `fix_en` high, `busy` is high for the two cycles after `res_valid` rises. The addressed bit of that buffer byte is then inverted, and no other byte changes.
- R6: A syndrome that is not a data pattern but has exactly one bit set gives `res_status` 2'b10. It also pulses `code_wr` together with `res_valid`.
- R7: Any other nonzero syndrome gives `res_status` 2'b11. `code_wr` stays low and the buffer is not modified.
- R8: On every accepted start, `code_new` takes the effective computed code. That code is `calc_code` when `compat_en` is 0, and (~`calc_code` | 24'h030000) when `compat_en` is 1. The syndrome is the effective code XOR `stored_code`.
- R9: A `start` while `busy` is high is ignored. `res_valid` does not rise and the held results do not change.
- R10: With `fix_en` low, a data error is reported but the buffer is left unchanged and `busy` stays low.
- R11: A host write stores `host_wdata` at `host_waddr`. `host_rdata` shows the byte at `host_raddr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the codes presented this cycle |
| fix_en | input | 1 | Repair a single data-bit error in the buffer |
| compat_en | input | 1 | Invert the computed code and force bits 17:16 before comparing |
| calc_code | input | 24 | Code computed over the chunk |
| stored_code | input | 24 | Code read from the spare area |
| host_we | input | 1 | Buffer write enable |
| host_waddr | input | 8 | Buffer write address |
| host_wdata | input | 8 | Buffer write data |
| host_raddr | input | 8 | Buffer read address |
| host_rdata | output | 8 | Buffer read data, one cycle latency |
| busy | output | 1 | Repair in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_status | output | 2 | 00 clean, 01 data bit, 10 stored code, 11 uncorrectable |
| res_byte | output | 8 | Byte address of the bad bit |
| res_bit | output | 3 | Bit index within that byte |
| code_wr | output | 1 | Stored code must be replaced |
| code_new | output | 24 | Effective computed code |

## Verification
The assertions assume that the host leaves the buffer alone while `busy` is high. The repair's write and its read-back would otherwise collide with host traffic. They also assume that `start` stays low during reset. The stimulus only writes and reads the buffer while no repair is under way. It does raise `start` on purpose during a repair, to exercise the ignore rule. Syndromes are built from the requirement formulas for corner addresses, corner bit indices, single-bit code damage and multi-bit patterns, with the compatibility transform on and off.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int CODE_W = 24;

  typedef enum logic [1:0] {
    KIND_CLEAN  = 2'b00,
    KIND_DATA   = 2'b01,
    KIND_CODE   = 2'b10,
    KIND_UNCORR = 2'b11
  } kind_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_RD   = 2'b01,
    SEQ_WR   = 2'b10
  } seq_t;
endpackage

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter logic [CODE_W-1:0] COMPAT_OR = 24'h030000
) (
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  input  logic              compat,
  output kind_t             kind,
  output logic [7:0]        byte_idx,
  output logic [2:0]        bit_idx,
  output logic [CODE_W-1:0] eff
);
  logic [CODE_W-1:0] syn;
  logic [3:0] lo_pair_ok, mid_pair_ok;
  logic [2:0] hi_pair_ok;
  logic [4:0] ones;

  assign eff = compat ? (~calc | COMPAT_OR) : calc;
  assign syn = eff ^ stored;

  // Each low/mid byte contributes four complementary pairs.
  for (genvar k = 0; k < 4; k++) begin : g_lo
    assign lo_pair_ok[k]  = syn[2*k+1] ^ syn[2*k];
    assign mid_pair_ok[k] = syn[8+2*k+1] ^ syn[8+2*k];
    assign byte_idx[4+k]  = syn[2*k+1];
    assign byte_idx[k]    = syn[8+2*k+1];
  end

  // Top byte: three pairs, its lowest two bits are free.
  for (genvar k = 1; k < 4; k++) begin : g_hi
    assign hi_pair_ok[k-1] = syn[16+2*k+1] ^ syn[16+2*k];
    assign bit_idx[k-1]    = syn[16+2*k+1];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) ones = ones + {4'd0, syn[i]};
  end

  always_comb begin
    if (syn == '0)
      kind = KIND_CLEAN;
    else if (&lo_pair_ok && &mid_pair_ok && &hi_pair_ok)
      kind = KIND_DATA;
    else if (ones == 5'd1)
      kind = KIND_CODE;
    else
      kind = KIND_UNCORR;
  end
endmodule

// File: rtl/hecc_byte_ram.sv
module hecc_byte_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hecc_fix_seq.sv
module hecc_fix_seq
  import hecc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] addr_in,
  input  logic [2:0]    bit_in,
  input  logic [7:0]    rd_byte,
  output logic          busy,
  output logic          fix_we,
  output logic [AW-1:0] fix_addr,
  output logic [7:0]    fix_wdata
);
  seq_t       state;
  logic [7:0] mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      fix_addr <= '0;
      mask     <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (go) begin
          state    <= SEQ_RD;
          fix_addr <= addr_in;
          mask     <= 8'd1 << bit_in;
        end
        SEQ_RD:  state <= SEQ_WR;
        SEQ_WR:  state <= SEQ_IDLE;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SEQ_IDLE);
  assign fix_we    = (state == SEQ_WR);
  assign fix_wdata = rd_byte ^ mask;
endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
  import hecc_pkg::*;
#(
  parameter int                CHUNK_BYTES = 256,
  parameter logic [CODE_W-1:0] COMPAT_OR   = 24'h030000,
  parameter int                AW          = $clog2(CHUNK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fix_en,
  input  logic              compat_en,
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  input  logic              host_we,
  input  logic [AW-1:0]     host_waddr,
  input  logic [7:0]        host_wdata,
  input  logic [AW-1:0]     host_raddr,
  output logic [7:0]        host_rdata,
  output logic              busy,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [AW-1:0]     res_byte,
  output logic [2:0]        res_bit,
  output logic              code_wr,
  output logic [CODE_W-1:0] code_new
);
  kind_t             cls_kind;
  logic [7:0]        cls_byte;
  logic [2:0]        cls_bit;
  logic [CODE_W-1:0] cls_eff;
  logic              accept, fix_go;
  logic              fix_we;
  logic [AW-1:0]     fix_addr;
  logic [7:0]        fix_wdata, ram_rdata;

  hecc_classify #(.COMPAT_OR(COMPAT_OR)) u_cls (
    .calc     (calc_code),
    .stored   (stored_code),
    .compat   (compat_en),
    .kind     (cls_kind),
    .byte_idx (cls_byte),
    .bit_idx  (cls_bit),
    .eff      (cls_eff)
  );

  assign accept = start & ~busy;
  assign fix_go = accept & fix_en & (cls_kind == KIND_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_status <= 2'b00;
      res_byte   <= '0;
      res_bit    <= '0;
      code_wr    <= 1'b0;
      code_new   <= '0;
    end else begin
      res_valid <= accept;
      code_wr   <= accept & (cls_kind == KIND_CODE);
      if (accept) begin
        res_status <= cls_kind;
        res_byte   <= (cls_kind == KIND_DATA) ? cls_byte[AW-1:0] : '0;
        res_bit    <= (cls_kind == KIND_DATA) ? cls_bit : '0;
        code_new   <= cls_eff;
      end
    end
  end

  hecc_fix_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (fix_go),
    .addr_in   (cls_byte[AW-1:0]),
    .bit_in    (cls_bit),
    .rd_byte   (ram_rdata),
    .busy      (busy),
    .fix_we    (fix_we),
    .fix_addr  (fix_addr),
    .fix_wdata (fix_wdata)
  );

  hecc_byte_ram #(.DEPTH(CHUNK_BYTES), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (host_we | fix_we),
    .waddr (fix_we ? fix_addr : host_waddr),
    .wdata (fix_we ? fix_wdata : host_wdata),
    .raddr (busy ? fix_addr : host_raddr),
    .rdata (ram_rdata)
  );

  assign host_rdata = ram_rdata;
endmodule

// File: rtl/hecc_corrector_chk.sv
module hecc_corrector_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       res_valid,
  input logic [1:0] res_status,
  input logic       code_wr
);
  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> res_valid);

  // R2
  valid_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(start));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !res_valid);

  // R6
  code_wr_status_chk: assert property (@(posedge clk) disable iff (rst)
    code_wr |-> (res_valid && res_status == 2'b10));

  // R5
  busy_only_for_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (res_valid && res_status == 2'b01));

  // R7
  uncorr_no_repair_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'b11) |-> (!busy && !code_wr));
endmodule

bind hecc_corrector hecc_corrector_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .res_valid  (res_valid),
  .res_status (res_status),
  .code_wr    (code_wr)
);

// File: tb/hecc_corrector_tb.sv
module hecc_corrector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, fix_en = 1'b0, compat_en = 1'b0;
  logic [23:0] calc_code = '0, stored_code = '0;
  logic        host_we = 1'b0;
  logic [7:0]  host_waddr = '0, host_wdata = '0, host_raddr = '0;
  logic [7:0]  host_rdata;
  logic        busy, res_valid, code_wr;
  logic [1:0]  res_status;
  logic [7:0]  res_byte;
  logic [2:0]  res_bit;
  logic [23:0] code_new;

  int n_chk = 0, n_bad = 0;
  bit rd_chk_en = 1'b0;

  always #2 clk = ~clk;

  hecc_corrector u_dut (
    .clk(clk), .rst(rst), .start(start), .fix_en(fix_en), .compat_en(compat_en),
    .calc_code(calc_code), .stored_code(stored_code),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .busy(busy), .res_valid(res_valid), .res_status(res_status),
    .res_byte(res_byte), .res_bit(res_bit), .code_wr(code_wr), .code_new(code_new)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  m_mem [256];
  int          m_cnt;
  logic        m_valid, m_cw, m_rd_ok;
  logic [1:0]  m_st;
  logic [7:0]  m_byte, m_rdata, m_fix_addr;
  logic [2:0]  m_bit, m_fix_bit;
  logic [23:0] m_code;

  function automatic void ref_eval(input logic [23:0] c, input logic [23:0] s,
                                   input logic cm, output logic [1:0] st,
                                   output logic [7:0] a, output logic [2:0] b,
                                   output logic [23:0] e);
    logic [23:0] sy;
    logic [7:0] d1, d2, d3;
    int n;
    e  = cm ? (~c | 24'h030000) : c;
    sy = e ^ s;
    d1 = sy[7:0]; d2 = sy[15:8]; d3 = sy[23:16];
    n = 0;
    for (int i = 0; i < 24; i++) if (sy[i]) n++;
    a = 8'd0; b = 3'd0;
    if (sy == 24'd0) st = 2'b00;
    else if ((((d1 ^ (d1 >> 1)) & 8'h55) == 8'h55) &&
             (((d2 ^ (d2 >> 1)) & 8'h55) == 8'h55) &&
             (((d3 ^ (d3 >> 1)) & 8'h54) == 8'h54)) begin
      st = 2'b01;
      a  = {d1[7], d1[5], d1[3], d1[1], d2[7], d2[5], d2[3], d2[1]};
      b  = {d3[7], d3[5], d3[3]};
    end else if (n == 1) st = 2'b10;
    else st = 2'b11;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_valid = 0; m_cw = 0; m_st = 0; m_byte = 0; m_bit = 0;
      m_code = 0; m_rd_ok = 0;
    end else begin
      logic [1:0] st; logic [7:0] a; logic [2:0] b; logic [23:0] e;
      m_valid = 0; m_cw = 0;
      m_rd_ok = rd_chk_en && (m_cnt == 0) && !(host_we && host_waddr == host_raddr);
      if (m_cnt == 0) m_rdata = m_mem[host_raddr];
      if (m_cnt == 1) m_mem[m_fix_addr] = m_mem[m_fix_addr] ^ (8'd1 << m_fix_bit);
      if (host_we) m_mem[host_waddr] = host_wdata;
      if (m_cnt > 0) m_cnt--;
      else if (start) begin
        ref_eval(calc_code, stored_code, compat_en, st, a, b, e);
        m_valid = 1; m_st = st; m_byte = a; m_bit = b; m_code = e;
        m_cw = (st == 2'b10);
        if (st == 2'b01 && fix_en) begin
          m_cnt = 2; m_fix_addr = a; m_fix_bit = b;
        end
      end
    end
  end

  task automatic fail_line(string tag, logic [31:0] act, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (res_valid !== m_valid)  fail_line("R2 cycle res_valid", res_valid, m_valid);
      if (busy !== (m_cnt > 0))   fail_line("R5 cycle busy", busy, m_cnt > 0);
      if (code_wr !== m_cw)       fail_line("R6 cycle code_wr", code_wr, m_cw);
      if (res_status !== m_st)    fail_line("R3 cycle res_status", res_status, m_st);
      if (res_byte !== m_byte)    fail_line("R3 cycle res_byte", res_byte, m_byte);
      if (res_bit !== m_bit)      fail_line("R4 cycle res_bit", res_bit, m_bit);
      if (code_new !== m_code)    fail_line("R8 cycle code_new", code_new, m_code);
      if (m_rd_ok && host_rdata !== m_rdata)
        fail_line("R11 cycle host_rdata", host_rdata, m_rdata);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) fail_line(tag, act, exp);
  endtask

  function automatic logic [23:0] data_syn(logic [7:0] a, logic [2:0] b, logic [1:0] free);
    logic [23:0] s;
    for (int k = 0; k < 4; k++) begin
      s[2*k+1] = a[4+k];   s[2*k] = ~a[4+k];
      s[8+2*k+1] = a[k];   s[8+2*k] = ~a[k];
    end
    for (int k = 1; k < 4; k++) begin
      s[16+2*k+1] = b[k-1]; s[16+2*k] = ~b[k-1];
    end
    s[17:16] = free;
    return s;
  endfunction

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  task automatic run(logic [23:0] c, logic [23:0] s, logic f, logic cm);
    calc_code = c; stored_code = s; fix_en = f; compat_en = cm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic read_byte(logic [7:0] a, output logic [7:0] d);
    host_raddr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  logic [7:0] rd;
  logic [23:0] cc;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset res_valid", res_valid, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset status", res_status, 0);
    rst = 1'b0;
    chk("R1 after reset code_new", code_new, 0);
    chk("R1 after reset code_wr", code_wr, 0);
    @(negedge clk);

    for (int i = 0; i < 256; i++) begin
      host_we = 1'b1; host_waddr = 8'(i); host_wdata = pat(i);
      @(negedge clk);
    end
    host_we = 1'b0;
    rd_chk_en = 1'b1;
    read_byte(8'd0, rd);   chk("R11 readback 0", rd, pat(0));
    read_byte(8'd200, rd); chk("R11 readback 200", rd, pat(200));

    // Clean
    run(24'hA5C31E, 24'hA5C31E, 1'b1, 1'b0);
    chk("R2 clean valid", res_valid, 1);
    chk("R2 clean status", res_status, 2'b00);
    @(negedge clk);
    chk("R2 valid one cycle", res_valid, 0);

    // Data error repaired: byte 0x5A bit 6
    cc = 24'h3C7711;
    run(cc, cc ^ data_syn(8'h5A, 3'd6, 2'b10), 1'b1, 1'b0);
    chk("R3 data status", res_status, 2'b01);
    chk("R3 data byte", res_byte, 8'h5A);
    chk("R4 data bit", res_bit, 3'd6);
    chk("R5 busy", busy, 1);
    repeat (3) @(negedge clk);
    read_byte(8'h5A, rd); chk("R5 repaired byte", rd, pat(8'h5A) ^ 8'h40);
    read_byte(8'h5B, rd); chk("R5 neighbour untouched", rd, pat(8'h5B));

    // Corners: byte 0 bit 0, byte 255 bit 7
    run(24'h000000, data_syn(8'h00, 3'd0, 2'b00), 1'b1, 1'b0);
    chk("R3 corner byte 0", res_byte, 8'h00);
    chk("R4 corner bit 0", res_bit, 3'd0);
    repeat (3) @(negedge clk);
    read_byte(8'h00, rd); chk("R5 byte 0 bit 0 flipped", rd, pat(0) ^ 8'h01);
    run(24'hFFFFFF, ~data_syn(8'hFF, 3'd7, 2'b11), 1'b1, 1'b0);
    chk("R3 corner byte 255", res_byte, 8'hFF);
    chk("R4 corner bit 7", res_bit, 3'd7);
    repeat (3) @(negedge clk);
    read_byte(8'hFF, rd); chk("R5 byte 255 bit 7 flipped", rd, pat(255) ^ 8'h80);

    // Stored code damaged
    run(24'h123456, 24'h123456 ^ 24'h800000, 1'b1, 1'b0);
    chk("R6 code status", res_status, 2'b10);
    chk("R6 code_wr pulse", code_wr, 1);
    chk("R6 code_new", code_new, 24'h123456);
    chk("R4 byte zero on code error", res_byte, 0);
    chk("R6 no repair busy", busy, 0);

    // Uncorrectable
    run(24'h00F00F, 24'h00F00F ^ 24'h000003, 1'b1, 1'b0);
    chk("R7 uncorr status", res_status, 2'b11);
    chk("R7 no code_wr", code_wr, 0);
    chk("R7 no busy", busy, 0);
    repeat (2) @(negedge clk);
    read_byte(8'h00, rd); chk("R7 buffer unchanged", rd, pat(0) ^ 8'h01);

    // Compatibility transform
    cc = ~24'h123456 | 24'h030000;
    run(24'h123456, cc, 1'b0, 1'b1);
    chk("R8 compat clean", res_status, 2'b00);
    chk("R8 compat code_new", code_new, cc);
    run(24'h123456, cc ^ 24'h000020, 1'b0, 1'b1);
    chk("R8 compat code error", res_status, 2'b10);

    // fix disabled
    run(24'h0, data_syn(8'h10, 3'd3, 2'b01), 1'b0, 1'b0);
    chk("R10 status reported", res_status, 2'b01);
    chk("R10 no busy", busy, 0);
    repeat (2) @(negedge clk);
    read_byte(8'h10, rd); chk("R10 byte unchanged", rd, pat(8'h10));

    // Start while busy
    run(24'h0, data_syn(8'h20, 3'd1, 2'b00), 1'b1, 1'b0);
    chk("R9 busy before second start", busy, 1);
    run(24'h0, 24'h000001, 1'b1, 1'b0);
    chk("R9 ignored start no valid", res_valid, 0);
    chk("R9 result held", res_status, 2'b01);
    repeat (3) @(negedge clk);
    read_byte(8'h20, rd); chk("R9 first repair done", rd, pat(8'h20) ^ 8'h02);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule